// File: doc/BRIEF.md
# Single-Cell Charger Phase Sequencer

This controller steps a single lithium cell through its charge phases: conditioning at low current, bulk charge, completion and automatic top-up. Its inputs are comparator results that some other logic has already filtered: the supply sits above the cell, the cell is under the conditioning threshold, the cell is under the top-up threshold, the taper current has been seen, and the level of the active-low enable pin. It also takes a one-cycle pulse once per second.

It drives the enables for the conditioning current, the bulk current and a small probe current. It also drives two active-low status lines and an active-low supply-good line. Two safety timers count the second pulses, one for conditioning and one for bulk charge. When either one runs out, the controller drops into a fault. How it recovers depends on the cell voltage. A cell above the top-up threshold is waited on until it sags below it. A cell below the threshold gets the probe current until it rises above it, and then the controller waits for it to sag again.

All outputs come straight from the registered phase. Any input change is therefore seen one clock later.

Top module: `chg_seq_top`

## Requirements
- R1: While `supply_ok` is low, the next cycle is sleep: all three current enables are 0 and `stat_a_n`, `stat_b_n` and `pwr_good_n` are all 1. Outside sleep, `pwr_good_n` is 0. Reset enters sleep.
- R2: A charge start with `cell_low` high enters conditioning: `pre_en`=1, `stat_a_n`=0, `stat_b_n`=0.
- R3: A charge start with `cell_low` low enters bulk charge: `fast_en`=1, `stat_a_n`=0, `stat_b_n`=1. Conditioning moves to bulk when `cell_low` falls. Bulk moves back to conditioning when `cell_low` rises.
- R4: If the cell is still under the conditioning threshold after PRE_TICKS second pulses in conditioning, the controller faults in the following cycle. A fault reports `stat_a_n`=1, `stat_b_n`=1 and drives no bulk or conditioning current. One pulse fewer leaves it in conditioning.
- R5: After FAST_TICKS pulses in bulk charge, the controller faults in the following cycle. One pulse fewer leaves it in bulk charge.
- R6: `taper_seen` during bulk charge enters completion: `stat_a_n`=1, `stat_b_n`=0, no current enable. Completion restarts a charge once `cell_rch` is high.
- R7: A fault raised with `cell_rch` high turns on `probe_en`. `probe_en` stays on until `cell_rch` falls, and the controller then waits. A fault raised with `cell_rch` low waits directly. A wait ends with a new charge start once `cell_rch` is high.
- R8: While `en_n` is high, charging is off: no current enable and both status lines at 1. When `en_n` returns low, a new charge starts, which clears any fault and every timer.
- R9: At most one of `pre_en`, `fast_en` and `probe_en` is 1 in any cycle.
- R10: Each safety timer restarts from zero every time its phase is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_ok | input | 1 | Supply is above the cell voltage |
| cell_low | input | 1 | Cell is under the conditioning threshold |
| cell_rch | input | 1 | Cell is under the top-up threshold |
| taper_seen | input | 1 | Charge current has tapered to the end level |
| en_n | input | 1 | Charge enable pin level, low enables |
| sec_tick | input | 1 | One-cycle pulse once per second |
| pre_en | output | 1 | Conditioning current enable |
| fast_en | output | 1 | Bulk current enable |
| probe_en | output | 1 | Fault probe current enable |
| stat_a_n | output | 1 | Status line A, 0 = on |
| stat_b_n | output | 1 | Status line B, 0 = on |
| pwr_good_n | output | 1 | Supply good, 0 = valid supply |

## Verification
The probe-current recovery path is the hardest state to reach. Getting there needs a full safety timeout, and the cell must also sit under the top-up threshold at the moment the timer expires. The bench runs with scaled-down timer limits and sets this up directly: it times out conditioning on a low cell, lets the cell rise, and then lets it sag again. The random phase holds each comparator input steady for several cycles, so timeouts and both recovery branches come up repeatedly, and a reference model decides the expected outputs.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;

    typedef enum logic [2:0] {
        ST_SLEEP = 3'd0,
        ST_OFF   = 3'd1,
        ST_PRE   = 3'd2,
        ST_FAST  = 3'd3,
        ST_DONE  = 3'd4,
        ST_WAIT  = 3'd5,
        ST_PROBE = 3'd6
    } chg_state_e;

    typedef struct packed {
        logic pre;
        logic fast;
        logic probe;
        logic stat_a_n;
        logic stat_b_n;
        logic pg_n;
    } chg_out_s;

    typedef struct packed {
        chg_state_e st;
    } chg_regs_s;

endpackage

// File: rtl/chg_tick_timer.sv
module chg_tick_timer #(
    parameter int LIMIT = 1800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TERM = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run)
            cnt_d = '0;
        else if (tick && cnt_q != TERM)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == TERM);

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TERM);
    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !expired);
endmodule

// File: rtl/chg_out_dec.sv
module chg_out_dec
    import chg_seq_pkg::*;
(
    input  chg_state_e st,
    output chg_out_s   o
);
    always_comb begin
        o = '{pre: 1'b0, fast: 1'b0, probe: 1'b0,
              stat_a_n: 1'b1, stat_b_n: 1'b1, pg_n: 1'b0};
        unique case (st)
            ST_SLEEP: o.pg_n = 1'b1;
            ST_PRE: begin
                o.pre = 1'b1; o.stat_a_n = 1'b0; o.stat_b_n = 1'b0;
            end
            ST_FAST: begin
                o.fast = 1'b1; o.stat_a_n = 1'b0;
            end
            ST_DONE:  o.stat_b_n = 1'b0;
            ST_PROBE: o.probe = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/chg_seq_top.sv
module chg_seq_top
    import chg_seq_pkg::*;
#(
    parameter int PRE_TICKS  = 1800,
    parameter int FAST_TICKS = 25200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic cell_low,
    input  logic cell_rch,
    input  logic taper_seen,
    input  logic en_n,
    input  logic sec_tick,
    output logic pre_en,
    output logic fast_en,
    output logic probe_en,
    output logic stat_a_n,
    output logic stat_b_n,
    output logic pwr_good_n
);
    chg_regs_s r_d, r_q;
    chg_out_s  dec;
    logic pre_exp, fast_exp;
    chg_state_e start_st, fault_st;

    chg_tick_timer #(.LIMIT(PRE_TICKS)) u_pre_tmr (
        .clk(clk), .rst_n(rst_n), .run(r_q.st == ST_PRE),
        .tick(sec_tick), .expired(pre_exp));

    chg_tick_timer #(.LIMIT(FAST_TICKS)) u_fast_tmr (
        .clk(clk), .rst_n(rst_n), .run(r_q.st == ST_FAST),
        .tick(sec_tick), .expired(fast_exp));

    always_comb begin
        start_st = cell_low ? ST_PRE : ST_FAST;
        fault_st = cell_rch ? ST_PROBE : ST_WAIT;
        r_d = r_q;
        if (!supply_ok)
            r_d.st = ST_SLEEP;
        else if (en_n)
            r_d.st = ST_OFF;
        else begin
            unique case (r_q.st)
                ST_SLEEP, ST_OFF: r_d.st = start_st;
                ST_PRE: begin
                    if (!cell_low)     r_d.st = ST_FAST;
                    else if (pre_exp)  r_d.st = fault_st;
                end
                ST_FAST: begin
                    if (fast_exp)        r_d.st = fault_st;
                    else if (cell_low)   r_d.st = ST_PRE;
                    else if (taper_seen) r_d.st = ST_DONE;
                end
                ST_DONE, ST_WAIT: if (cell_rch) r_d.st = start_st;
                ST_PROBE: if (!cell_rch) r_d.st = ST_WAIT;
                default: r_d.st = ST_SLEEP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_SLEEP};
        else        r_q <= r_d;
    end

    chg_out_dec u_dec (.st(r_q.st), .o(dec));

    assign pre_en     = dec.pre;
    assign fast_en    = dec.fast;
    assign probe_en   = dec.probe;
    assign stat_a_n   = dec.stat_a_n;
    assign stat_b_n   = dec.stat_b_n;
    assign pwr_good_n = dec.pg_n;

    assert_one_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pre_en, fast_en, probe_en}));
    assert_sleep_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (pwr_good_n && stat_a_n && stat_b_n && !pre_en && !fast_en && !probe_en));
    assert_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |=> (!pre_en && !fast_en && !probe_en && stat_a_n && stat_b_n));
    assert_probe_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_en && !cell_rch && supply_ok && !en_n) |=> (!probe_en && stat_a_n && stat_b_n));
    assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_a_n && !stat_b_n && cell_rch && supply_ok && !en_n) |=> (pre_en || fast_en));
endmodule

// File: tb/tb_chg_seq_top.sv
module tb_chg_seq_top;
    localparam int PT = 5;
    localparam int FT = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0, cell_low = 1'b0, cell_rch = 1'b0;
    logic taper_seen = 1'b0, en_n = 1'b0, sec_tick = 1'b0;
    logic pre_en, fast_en, probe_en, stat_a_n, stat_b_n, pwr_good_n;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    chg_seq_top #(.PRE_TICKS(PT), .FAST_TICKS(FT)) dut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .cell_low(cell_low),
        .cell_rch(cell_rch), .taper_seen(taper_seen), .en_n(en_n),
        .sec_tick(sec_tick), .pre_en(pre_en), .fast_en(fast_en),
        .probe_en(probe_en), .stat_a_n(stat_a_n), .stat_b_n(stat_b_n),
        .pwr_good_n(pwr_good_n));

    // Reference model: 0 sleep,1 off,2 pre,3 fast,4 done,5 wait,6 probe
    int m_st = 0;
    int m_cnt = 0;

    function automatic int model_next(int st, int cnt);
        int start, flt;
        start = cell_low ? 2 : 3;
        flt   = cell_rch ? 6 : 5;
        if (!supply_ok) return 0;
        if (en_n) return 1;
        case (st)
            0, 1: return start;
            2: if (!cell_low) return 3; else if (cnt >= PT) return flt; else return 2;
            3: if (cnt >= FT) return flt; else if (cell_low) return 2;
               else if (taper_seen) return 4; else return 3;
            4, 5: return cell_rch ? start : st;
            6: return cell_rch ? 6 : 5;
            default: return 0;
        endcase
    endfunction

    function automatic logic [5:0] model_out(int st);
        // {pre, fast, probe, stat_a_n, stat_b_n, pwr_good_n}
        case (st)
            0: return 6'b000111;
            2: return 6'b100000;
            3: return 6'b010010;
            4: return 6'b000100;
            6: return 6'b001110;
            default: return 6'b000110;
        endcase
    endfunction

    function automatic string tag_of(int st);
        case (st)
            0: return "R1";
            1: return "R8";
            2: return "R2";
            3: return "R3";
            4: return "R6";
            6: return "R7";
            default: return "R7";
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st <= 0; m_cnt <= 0;
        end else begin
            int nx;
            nx = model_next(m_st, m_cnt);
            if (nx != m_st) m_cnt <= 0;
            else if ((m_st == 2 || m_st == 3) && sec_tick) m_cnt <= m_cnt + 1;
            else m_cnt <= m_cnt;
            m_st <= nx;
        end
    end

    function automatic logic [5:0] dut_out();
        return {pre_en, fast_en, probe_en, stat_a_n, stat_b_n, pwr_good_n};
    endfunction

    task automatic check(string tag, logic [5:0] exp);
        checks++;
        if (dut_out() !== exp) begin
            errors++;
            $display("FAIL %s: outputs %b expected %b at %0t", tag, dut_out(), exp, $time);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tick();
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    localparam logic [5:0] O_SLEEP = 6'b000111, O_PRE = 6'b100000,
                           O_FAST = 6'b010010, O_DONE = 6'b000100,
                           O_IDLE = 6'b000110, O_PROBE = 6'b001110;

    initial begin
        cyc(2);
        check("R1 reset", O_SLEEP);
        rst_n = 1'b1;
        cyc(2);
        check("R1 no supply", O_SLEEP);
        // R2: start with low cell
        supply_ok = 1'b1; cell_low = 1'b1; cell_rch = 1'b1;
        cyc(1);
        check("R2 precharge start", O_PRE);
        // R4: PT-1 ticks keep precharge, PT-th expires
        for (int i = 0; i < PT - 1; i++) pulse_tick();
        cyc(1);
        check("R4 before limit", O_PRE);
        pulse_tick();
        check("R4 limit reached same cycle", O_PRE);
        cyc(1);
        check("R4 R7 fault with probe", O_PROBE);
        // R7: probe stays while below top-up, leaves when above
        cell_low = 1'b0;
        cyc(2);
        check("R7 probe held", O_PROBE);
        cell_rch = 1'b0;
        cyc(1);
        check("R7 probe off, waiting", O_IDLE);
        cyc(3);
        check("R7 wait held", O_IDLE);
        cell_rch = 1'b1;
        cyc(1);
        check("R7 R3 restart to fast", O_FAST);
        // R10: re-entry restarts the fast timer
        for (int i = 0; i < FT - 1; i++) pulse_tick();
        cell_low = 1'b1;
        cyc(1);
        check("R3 fast back to pre", O_PRE);
        cell_low = 1'b0;
        cyc(1);
        check("R3 pre to fast", O_FAST);
        for (int i = 0; i < FT - 1; i++) pulse_tick();
        cyc(1);
        check("R10 timer restarted", O_FAST);
        cell_rch = 1'b0;
        pulse_tick();
        cyc(1);
        check("R5 fast timeout, wait path", O_IDLE);
        // R8: enable toggle clears fault
        en_n = 1'b1;
        cyc(1);
        check("R8 disabled", O_IDLE);
        en_n = 1'b0;
        cyc(1);
        check("R8 fault cleared by enable edge", O_FAST);
        // R6: taper, done, top-up restart
        taper_seen = 1'b1;
        cyc(1);
        check("R6 done", O_DONE);
        taper_seen = 1'b0;
        cyc(3);
        check("R6 done held", O_DONE);
        cell_rch = 1'b1;
        cyc(1);
        check("R6 top-up restart", O_FAST);
        supply_ok = 1'b0;
        cyc(1);
        check("R1 supply lost", O_SLEEP);

        // Random phase against the model
        rst_n = 1'b0;
        void'($urandom(32'd2024));
        cyc(2);
        rst_n = 1'b1;
        supply_ok = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 99) < 3)  supply_ok = ($urandom_range(0, 9) != 0);
            if ($urandom_range(0, 99) < 2)  en_n      = ($urandom_range(0, 5) == 0);
            if ($urandom_range(0, 99) < 6)  cell_low  = $urandom_range(0, 1);
            if ($urandom_range(0, 99) < 6)  cell_rch  = $urandom_range(0, 1);
            if ($urandom_range(0, 99) < 4)  taper_seen = $urandom_range(0, 1);
            sec_tick = ($urandom_range(0, 2) == 0);
            @(negedge clk);
            check(tag_of(m_st), model_out(m_st));
            checks++;
            if ($countones({pre_en, fast_en, probe_en}) > 1) begin
                errors++;
                $display("FAIL R9: enables %b expected at most one set",
                         {pre_en, fast_en, probe_en});
            end
        end
        sec_tick = 1'b0;
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule